// File: doc/BRIEF.md
# Block Address Translator

This block maps large, naturally aligned regions of effective address space onto physical memory without any page table. It keeps a small set of translation pairs, split into an instruction set and a data set of equal size. Each pair is an upper word, which describes the effective region and who may use it, and a lower word, which describes the physical region, its memory attributes and its access rights. Software loads and reads the pairs through a simple synchronous register port.

For each access, the caller presents an effective address and three flags: instruction or data, supervisor or user, and read or write. Only the pairs of the matching side are searched. The result appears combinationally from the stored pairs in the same cycle. It consists of a hit flag, a 36-bit physical address, four cache and ordering attributes, and a protection-fault flag.

Region sizes run from 128 KB to 256 MB. The size is set by a thermometer-coded length mask. Physical address bits above 32 are packed into spare bits of the lower word.

Top module: `blk_xlate`

## Requirements
- R1: After reset every pair reads back as zero, and no access hits.
- R2: A register write stores the 32-bit word, and a read at the same address returns it. The register address has these fields: bit 0 selects the lower (1) or upper (0) word, bits 2:1 give the pair number, and bit 3 selects the data (1) or instruction (0) set.
- R3: A pair hits when effective address bits 31:17 equal upper-word bits 31:17 in every position where the length mask (upper bits 12:2, with mask bit 0 lined up with address bit 17) is zero. An all-zero mask gives a 128 KB region.
- R4: Each additional low-order one in the mask doubles the region size. A mask of eleven ones (0x1ffc in the upper word) gives a 256 MB region.
- R5: A supervisor access can hit a pair only if upper bit 1 is set, and a user access only if upper bit 0 is set.
- R6: An instruction access searches only the instruction set, and a data access searches only the data set.
- R7: Physical bits 31:17 come from lower bits 31:17 where the mask is zero, and from the effective address where the mask is one. Physical bits 16:0 equal effective bits 16:0. Physical bits 35:33 come from lower bits 11:9, and physical bit 32 comes from lower bit 2.
- R8: On a hit, the write-through, cache-inhibit, coherence and guarded outputs equal lower bits 6, 5, 4 and 3.
- R9: Lower bits 1:0 hold the protection code. Code 00 faults on any access, 01 and 11 fault on writes only, and 10 never faults. The fault output is raised only on a hit.
- R10: When several pairs hit, the lowest-numbered pair supplies the result.
- R11: Bit 3 of an instruction-set lower word is always stored as zero, so the guarded output is never set for an instruction access.
- R12: On a miss, the hit, fault and attribute outputs and the physical address are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address: set, pair number, word select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data at cfg_addr |
| acc_ea | input | 32 | Effective address of the access |
| acc_data | input | 1 | 1 = data access, 0 = instruction access |
| acc_super | input | 1 | 1 = supervisor, 0 = user |
| acc_write | input | 1 | 1 = write, 0 = read |
| xl_hit | output | 1 | A pair translated the access |
| xl_pa | output | 36 | Physical address |
| xl_wt | output | 1 | Write-through attribute |
| xl_ci | output | 1 | Cache-inhibit attribute |
| xl_coh | output | 1 | Coherence attribute |
| xl_grd | output | 1 | Guarded attribute |
| xl_fault | output | 1 | Protection violation |

## Verification
The assertions check several properties on every cycle:
- a fault never appears without a hit;
- an instruction access never reports guarded storage;
- a miss leaves the address and attributes at zero;
- read-back data and the translation result hold steady while neither the pairs nor the inputs change.

Other behaviours can only be shown by the directed scenarios:
- the masked compare at several region sizes;
- the packing of the high physical bits;
- the meaning of each protection code;
- privilege gating;
- set selection;
- lowest-pair priority.

// File: rtl/blk_xlate.sv
module blk_xlate #(
  parameter int NPAIR = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [3:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic [31:0] acc_ea,
  input  logic        acc_data,
  input  logic        acc_super,
  input  logic        acc_write,
  output logic        xl_hit,
  output logic [35:0] xl_pa,
  output logic        xl_wt,
  output logic        xl_ci,
  output logic        xl_coh,
  output logic        xl_grd,
  output logic        xl_fault
);
  localparam int IDX_W = $clog2(NPAIR);
  localparam int NENT  = 2 * NPAIR;
  localparam int AW    = IDX_W + 2;

  logic [31:0] upr [NENT];
  logic [31:0] lwr [NENT];

  wire [IDX_W:0] cfg_sel = cfg_addr[AW-1:1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NENT; k++) begin
        upr[k] <= '0;
        lwr[k] <= '0;
      end
    end else if (cfg_we) begin
      if (cfg_addr[0])
        lwr[cfg_sel] <= cfg_addr[AW-1] ? cfg_wdata : (cfg_wdata & ~32'h8);
      else
        upr[cfg_sel] <= cfg_wdata;
    end
  end

  assign cfg_rdata = cfg_addr[0] ? lwr[cfg_sel] : upr[cfg_sel];

  logic [NPAIR-1:0] hv;
  logic [14:0]      msk [NPAIR];

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    localparam logic [IDX_W-1:0] GI = IDX_W'(g);
    wire [31:0] u  = upr[{acc_data, GI}];
    wire        ok = acc_super ? u[1] : u[0];
    assign msk[g] = {4'b0, u[12:2]};
    assign hv[g]  = ok && (((acc_ea[31:17] ^ u[31:17]) & ~msk[g]) == 15'd0);
  end

  logic [IDX_W-1:0] win;
  always_comb begin
    win = '0;
    for (int k = NPAIR - 1; k >= 0; k--)
      if (hv[k]) win = IDX_W'(k);
  end

  wire [31:0] wl = lwr[{acc_data, win}];
  wire [14:0] wm = msk[win];

  assign xl_hit   = |hv;
  assign xl_pa    = xl_hit ? {wl[11:9], wl[2], (wl[31:17] & ~wm) | (acc_ea[31:17] & wm), acc_ea[16:0]} : 36'd0;
  assign xl_wt    = xl_hit & wl[6];
  assign xl_ci    = xl_hit & wl[5];
  assign xl_coh   = xl_hit & wl[4];
  assign xl_grd   = xl_hit & wl[3];
  assign xl_fault = xl_hit & ((wl[1:0] == 2'b00) | (acc_write & wl[0]));

  // R9
  fault_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xl_fault |-> xl_hit);

  // R11
  instr_grd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_data |-> !xl_grd);

  // R12
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_hit |-> (xl_pa == 36'd0 && !xl_wt && !xl_ci && !xl_coh && !xl_fault));

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cfg_we) && $stable(cfg_addr)) |-> $stable(cfg_rdata));

  // R3
  xl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cfg_we) && $stable(acc_ea) && $stable(acc_data) && $stable(acc_super)
     && $stable(acc_write)) |-> ($stable(xl_hit) && $stable(xl_pa) && $stable(xl_fault)));
endmodule

// File: tb/blk_xlate_tb_top.sv
module blk_xlate_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [3:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_rdata;
  logic [31:0] acc_ea = 0;
  logic        acc_data = 0, acc_super = 0, acc_write = 0;
  logic        xl_hit, xl_wt, xl_ci, xl_coh, xl_grd, xl_fault;
  logic [35:0] xl_pa;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  blk_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_ea(acc_ea),
    .acc_data(acc_data), .acc_super(acc_super), .acc_write(acc_write),
    .xl_hit(xl_hit), .xl_pa(xl_pa), .xl_wt(xl_wt), .xl_ci(xl_ci),
    .xl_coh(xl_coh), .xl_grd(xl_grd), .xl_fault(xl_fault));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic acc(input logic [31:0] ea, input logic d, input logic s, input logic w);
    @(negedge clk);
    acc_ea = ea; acc_data = d; acc_super = s; acc_write = w;
    #1;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(4'h9, v);  chk("R1 rdata", v, 0);
    rd(4'h2, v);  chk("R1 rdata", v, 0);
    acc(32'h0, 1, 1, 0); chk("R1 hit", xl_hit, 0);
    chk("R12 pa", xl_pa, 0);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    wr(4'hA, 32'h1234_5677); rd(4'hA, v); chk("R2 readback", v, 32'h1234_5677);
    wr(4'h5, 32'hDEAD_BEEF); rd(4'h5, v); chk("R2 readback", v, 32'hDEAD_BEE7);
    wr(4'h5, 32'h0);
  endtask

  task automatic t_small;
    wr(4'h8, 32'h8000_0003); wr(4'h9, 32'h4000_0012);
    acc(32'h8001_2345, 1, 1, 0);
    chk("R3 hit", xl_hit, 1); chk("R7 pa", xl_pa, 36'h0_4001_2345);
    chk("R8 attr", {xl_wt, xl_ci, xl_coh, xl_grd}, 4'b0010);
    acc(32'h8002_0000, 1, 1, 0); chk("R3 miss 128K edge", xl_hit, 0);
    chk("R12 attrs", {xl_pa, xl_coh, xl_fault}, 0);
    acc(32'h8001_0000, 1, 1, 1); chk("R9 rw no fault", xl_fault, 0);
  endtask

  task automatic t_large;
    wr(4'hA, 32'h1000_1FFF); wr(4'hB, 32'h2000_0E46);
    acc(32'h1ABC_DEF0, 1, 0, 0);
    chk("R4 256M hit", xl_hit, 1); chk("R7 high pa", xl_pa, 36'hF_2ABC_DEF0);
    chk("R8 wt", {xl_wt, xl_ci, xl_coh, xl_grd}, 4'b1000);
    acc(32'h2000_0000, 1, 0, 0); chk("R4 256M miss", xl_hit, 0);
  endtask

  task automatic t_mid;
    wr(4'hC, 32'h0060_001E); wr(4'hD, 32'h0300_0001);
    acc(32'h006F_1234, 1, 1, 0);
    chk("R4 1M hit", xl_hit, 1); chk("R7 1M pa", xl_pa, 36'h0_030F_1234);
    chk("R9 ro read", xl_fault, 0);
    acc(32'h006F_1234, 1, 1, 1); chk("R9 ro write", xl_fault, 1);
    acc(32'h0070_0000, 1, 1, 0); chk("R4 1M miss", xl_hit, 0);
    acc(32'h006F_1234, 1, 0, 0); chk("R5 user blocked", xl_hit, 0);
  endtask

  task automatic t_prot;
    wr(4'hE, 32'h0400_0003); wr(4'hF, 32'h0000_0000);
    acc(32'h0401_0000, 1, 1, 0); chk("R9 none read", xl_fault, 1);
    wr(4'hF, 32'h0000_0003);
    acc(32'h0401_0000, 1, 1, 0); chk("R9 code11 read", xl_fault, 0);
    acc(32'h0401_0000, 1, 1, 1); chk("R9 code11 write", xl_fault, 1);
    wr(4'hF, 32'h0000_003A);
    acc(32'h0401_0000, 1, 0, 1);
    chk("R8 ci coh grd", {xl_wt, xl_ci, xl_coh, xl_grd, xl_fault}, 5'b01110);
    wr(4'hE, 32'h0400_0002);
    acc(32'h0401_0000, 1, 0, 0); chk("R5 vs only user", xl_hit, 0);
  endtask

  task automatic t_instr;
    logic [31:0] v;
    acc(32'h8001_2345, 0, 1, 0); chk("R6 instr set empty", xl_hit, 0);
    wr(4'h0, 32'h8000_0003); wr(4'h1, 32'h5000_000A);
    rd(4'h1, v); chk("R11 grd stripped", v, 32'h5000_0002);
    acc(32'h8001_2345, 0, 1, 0);
    chk("R6 instr hit", xl_pa, 36'h0_5001_2345); chk("R11 grd out", xl_grd, 0);
  endtask

  task automatic t_prio;
    wr(4'hE, 32'h8000_0003); wr(4'hF, 32'h7000_0002);
    acc(32'h8001_2345, 1, 1, 0); chk("R10 lowest wins", xl_pa, 36'h0_4001_2345);
    wr(4'h8, 32'h0);
    acc(32'h8001_2345, 1, 1, 0); chk("R10 next pair", xl_pa, 36'h0_7001_2345);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        t_reset; t_regs; t_small; t_large; t_mid; t_prot; t_instr; t_prio;
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule